// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter units. Each unit keeps a count in two bytes, a low byte and a high byte. A single configuration register holds one four-bit nibble per unit. That nibble picks the unit's counting mode, its clock source and its gating. A separate control register holds the run bit of each unit. A unit can count an internal tick, which fires once every `TICK_DIV` system clocks (12 by default). It can instead count falling edges on its own count pin. When a unit's count wraps past its top value, the unit raises a sticky overflow flag. A one-cycle acknowledge pulse from the interrupt logic clears that flag.

The registers sit behind a small address/data port. A write takes effect on the clock edge. A read is combinational from the address. Each unit's mode field acts as its state: `MODE_PRE13`, `MODE_FULL16`, `MODE_RELOAD8` or `MODE_SPLIT`. The only transition is a configuration write, and it may move a unit from any mode to any other. A mode change takes effect from the edge after the write; the counts are kept across it. In `MODE_SPLIT`, unit 0 becomes two 8-bit counters. Its high byte is then driven by unit 1's run bit and reports through unit 1's flag. Unit 1 in `MODE_SPLIT` freezes its count.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all of these read zero: the configuration register, the control register, all four count bytes and both overflow flags.
- R2: Register addresses are 0 = configuration, 1 = control, 2/3 = unit 0 low/high byte, 4/5 = unit 1 low/high byte. Reads of addresses 6 and 7 return 0. A write updates the addressed byte on the next edge and reads back unchanged. A write to either count byte of a unit suspends that unit's counting in that cycle, so the unwritten byte holds.
- R3: Configuration nibble layout is bit 3 gate, bit 2 source select, bits 1:0 mode. Unit 0 owns bits 3:0 and unit 1 owns bits 7:4. In mode 00 the low five bits of the low byte count from 0 to 31. At each wrap they carry into the high byte. The low byte's bits 7:5 hold. When the high byte is 0xFF and the prescaler wraps, the count goes to zero and the flag is raised.
- R4: In mode 01 the high and low bytes form one 16-bit count. Going from 0xFFFF to 0x0000 raises the flag.
- R5: In mode 10 only the low byte counts. When it goes past 0xFF, it is reloaded from the high byte, which never changes, and the flag is raised.
- R6: With unit 0 in mode 11, its low byte counts as an 8-bit counter under unit 0's run, gate and source settings, and raises flag 0 when it wraps. Its high byte counts internal ticks whenever unit 1's run bit is set, and raises flag 1 when it wraps.
- R7: With unit 1 in mode 11, both of its count bytes hold their values.
- R8: A unit counts only while its run bit is set (control bit 0 for unit 0, bit 1 for unit 1). When the unit's gate bit is 1, its gate pin must also be high.
- R9: With source select 0 a unit counts internal ticks. With source select 1 it counts falling edges of its count pin. The pin is sampled on each tick, and an edge is a 1 followed by a 0 on two consecutive ticks. At most one count is taken per tick.
- R10: Overflow flags are sticky, and an acknowledge pulse clears a flag that is not being set in the same cycle. Control register bits 5:4 read flags 1:0. Writes to control bits 7:2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cnt_pin | input | 2 | External event pins, one per unit |
| gate_pin | input | 2 | Gate pins, one per unit |
| ovf_ack | input | 2 | Flag acknowledge pulses, one per unit |
| ovf_flag | output | 2 | Sticky overflow flags, one per unit |

## Verification
The assertions check these behaviours on every cycle:
- the reset values;
- write-through of unit 0's low byte;
- count hold for a stopped unit, for a gated-off unit and for unit 1 in split mode;
- a flag only rises on a running unit, and an acknowledge clears the flag of a stopped unit.

The exact counting arithmetic can only be shown by the bench's scenarios, which compare every read and both flags with a reference model computed from the requirements. These include the 13-bit carry, the 16-bit wrap, reload from the high byte, split-mode borrowing of the other run bit, and edge detection on tick samples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_PRE13   = 2'b00,
        MODE_FULL16  = 2'b01,
        MODE_RELOAD8 = 2'b10,
        MODE_SPLIT   = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam int CFG_W = 4;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CNT_W-1:0] div_q;

    assign tick = (div_q == CNT_W'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic prev_q;

    assign fall = tick & prev_q & ~pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (tick) begin
            prev_q <= pin;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              inc,
    input  logic              aux_inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf,
    output logic              aux_ovf
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [BYTE_W-1:0]   lo_d, hi_d;
    logic [2*BYTE_W-1:0] wide;

    always_comb begin
        lo_d    = lo_q;
        hi_d    = hi_q;
        ovf     = 1'b0;
        aux_ovf = 1'b0;
        wide    = {hi_q, lo_q} + 1'b1;
        if (wr_lo) begin
            lo_d = wdata;
        end else if (wr_hi) begin
            hi_d = wdata;
        end else begin
            unique case (mode)
                MODE_PRE13: begin
                    if (inc) begin
                        if (lo_q[PRE_W-1:0] == PRE_MAX) begin
                            lo_d[PRE_W-1:0] = '0;
                            hi_d            = hi_q + 1'b1;
                            ovf             = &hi_q;
                        end else begin
                            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                        end
                    end
                end
                MODE_FULL16: begin
                    if (inc) begin
                        {hi_d, lo_d} = wide;
                        ovf          = &{hi_q, lo_q};
                    end
                end
                MODE_RELOAD8: begin
                    if (inc) begin
                        if (&lo_q) begin
                            lo_d = hi_q;
                            ovf  = 1'b1;
                        end else begin
                            lo_d = lo_q + 1'b1;
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (SPLIT_OK) begin
                        if (inc) begin
                            lo_d = lo_q + 1'b1;
                            ovf  = &lo_q;
                        end
                        if (aux_inc) begin
                            hi_d    = hi_q + 1'b1;
                            aux_ovf = &hi_q;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5,
    parameter int TICK_DIV = 12,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        ovf_ack,
    output logic [1:0]        ovf_flag
);
    localparam int NUM_UNITS = 2;
    localparam int MODE_W    = NUM_UNITS * CFG_W;

    logic [MODE_W-1:0]    mode_q;
    logic [NUM_UNITS-1:0] run_q;
    logic [NUM_UNITS-1:0] flag_q;
    logic                 tick;
    logic [NUM_UNITS-1:0] fall, inc, ovf, aux_ovf, aux_inc;
    logic [NUM_UNITS-1:0] wr_lo, wr_hi;
    logic [BYTE_W-1:0]    lo_q [NUM_UNITS];
    logic [BYTE_W-1:0]    hi_q [NUM_UNITS];
    logic [NUM_UNITS-1:0] flag_set;

    tmr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    assign aux_inc = {1'b0, tick & run_q[1]};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        tmr_cfg_t cfg;
        logic     en;

        assign cfg = tmr_cfg_t'(mode_q[u*CFG_W +: CFG_W]);
        assign en  = run_q[u] & (~cfg.gate | gate_pin[u]);
        assign inc[u] = en & (cfg.ext_sel ? fall[u] : tick);
        assign wr_lo[u] = bus_wr && (bus_addr == ADDR_W'(2*u + 2));
        assign wr_hi[u] = bus_wr && (bus_addr == ADDR_W'(2*u + 3));

        tmr_edge u_edge (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .pin(cnt_pin[u]), .fall(fall[u])
        );

        tmr_unit #(
            .BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_OK(u == 0)
        ) u_core (
            .clk(clk), .rst_n(rst_n), .mode(cfg.mode),
            .inc(inc[u]), .aux_inc(aux_inc[u]),
            .wr_lo(wr_lo[u]), .wr_hi(wr_hi[u]), .wdata(bus_wdata),
            .lo_q(lo_q[u]), .hi_q(hi_q[u]),
            .ovf(ovf[u]), .aux_ovf(aux_ovf[u])
        );
    end

    assign flag_set = {ovf[1] | aux_ovf[0] | aux_ovf[1], ovf[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_W'(0)) mode_q <= bus_wdata[MODE_W-1:0];
            if (bus_wr && bus_addr == ADDR_W'(1)) run_q  <= bus_wdata[NUM_UNITS-1:0];
            flag_q <= (flag_q & ~ovf_ack) | flag_set;
        end
    end

    assign ovf_flag = flag_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(0): bus_rdata = BYTE_W'(mode_q);
            ADDR_W'(1): bus_rdata = BYTE_W'({2'b00, flag_q, 2'b00, run_q});
            ADDR_W'(2): bus_rdata = lo_q[0];
            ADDR_W'(3): bus_rdata = hi_q[0];
            ADDR_W'(4): bus_rdata = lo_q[1];
            ADDR_W'(5): bus_rdata = hi_q[1];
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [1:0]        gate_pin,
    input logic [1:0]        ovf_ack,
    input logic [1:0]        ovf_flag,
    input logic [7:0]        mode_q,
    input logic [1:0]        run_q,
    input logic [BYTE_W-1:0] lo0,
    input logic [BYTE_W-1:0] hi0,
    input logic [BYTE_W-1:0] lo1,
    input logic [BYTE_W-1:0] hi1
);
    logic wr_u0, wr_u1;
    assign wr_u0 = bus_wr && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3));
    assign wr_u1 = bus_wr && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(5));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ovf_flag == 2'b00 && run_q == 2'b00 && mode_q == 8'h00
                          && lo0 == '0 && hi0 == '0 && lo1 == '0 && hi1 == '0));

    assert_write_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(2)) |=> (lo0 == $past(bus_wdata)));

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && mode_q[1:0] != 2'b11 && !wr_u0) |=> ($stable(lo0) && $stable(hi0)));

    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3] && !gate_pin[0] && mode_q[1:0] != 2'b11 && !wr_u0)
        |=> ($stable(lo0) && $stable(hi0)));

    assert_split_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'b11 && !wr_u1) |=> ($stable(lo1) && $stable(hi1)));

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag[0]) |-> $past(run_q[0]));

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack[0] && !run_q[0]) |=> !ovf_flag[0]);
endmodule

bind tmr_pair tmr_pair_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .gate_pin(gate_pin), .ovf_ack(ovf_ack),
    .ovf_flag(ovf_flag), .mode_q(mode_q), .run_q(run_q),
    .lo0(lo_q[0]), .hi0(hi_q[0]), .lo1(lo_q[1]), .hi1(hi_q[1])
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b11;
    logic [1:0] ovf_ack = 2'b00;
    logic [1:0] ovf_flag;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    tmr_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    always #10 clk = ~clk;

    // reference model, built from the requirements
    int       m_pre;
    bit [1:0] m_prev, m_run, m_flag, m_set, m_fall, m_inc;
    bit [7:0] m_mode;
    bit [7:0] m_lo [2];
    bit [7:0] m_hi [2];
    bit       m_tk, m_aux, m_en;
    bit [15:0] m_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_prev = 0; m_run = 0; m_flag = 0; m_mode = 0;
            for (int u = 0; u < 2; u++) begin m_lo[u] = 0; m_hi[u] = 0; end
        end else begin
            m_tk  = (m_pre == 11);
            m_aux = m_tk && m_run[1];
            m_set = 2'b00;
            for (int u = 0; u < 2; u++) begin
                m_fall[u] = m_tk && m_prev[u] && !cnt_pin[u];
                m_en      = m_run[u] && (!m_mode[u*4+3] || gate_pin[u]);
                m_inc[u]  = m_en && (m_mode[u*4+2] ? m_fall[u] : m_tk);
            end
            for (int u = 0; u < 2; u++) begin
                if (bus_wr && int'(bus_addr) == 2 + 2*u) m_lo[u] = bus_wdata;
                else if (bus_wr && int'(bus_addr) == 3 + 2*u) m_hi[u] = bus_wdata;
                else begin
                    case (m_mode[u*4 +: 2])
                        2'b00: if (m_inc[u]) begin
                            if (m_lo[u][4:0] == 5'd31) begin
                                m_lo[u][4:0] = 5'd0;
                                if (m_hi[u] == 8'hFF) m_set[u] = 1'b1;
                                m_hi[u] = m_hi[u] + 8'd1;
                            end else m_lo[u][4:0] = m_lo[u][4:0] + 5'd1;
                        end
                        2'b01: if (m_inc[u]) begin
                            if (m_lo[u] == 8'hFF && m_hi[u] == 8'hFF) m_set[u] = 1'b1;
                            m_w = {m_hi[u], m_lo[u]} + 16'd1;
                            m_hi[u] = m_w[15:8]; m_lo[u] = m_w[7:0];
                        end
                        2'b10: if (m_inc[u]) begin
                            if (m_lo[u] == 8'hFF) begin m_lo[u] = m_hi[u]; m_set[u] = 1'b1; end
                            else m_lo[u] = m_lo[u] + 8'd1;
                        end
                        default: if (u == 0) begin
                            if (m_inc[0]) begin
                                if (m_lo[0] == 8'hFF) m_set[0] = 1'b1;
                                m_lo[0] = m_lo[0] + 8'd1;
                            end
                            if (m_aux) begin
                                if (m_hi[0] == 8'hFF) m_set[1] = 1'b1;
                                m_hi[0] = m_hi[0] + 8'd1;
                            end
                        end
                    endcase
                end
            end
            if (bus_wr && bus_addr == 3'd0) m_mode = bus_wdata;
            if (bus_wr && bus_addr == 3'd1) m_run = bus_wdata[1:0];
            m_flag = (m_flag & ~ovf_ack) | m_set;
            if (m_tk) m_prev = cnt_pin;
            m_pre = m_tk ? 0 : m_pre + 1;
        end
    end

    function automatic bit [7:0] exp_read(input bit [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return {2'b00, m_flag, 2'b00, m_run};
            3'd2: return m_lo[0];
            3'd3: return m_hi[0];
            3'd4: return m_lo[1];
            3'd5: return m_hi[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp_read(bus_addr)) begin
            errors++;
            $display("FAIL %s: read addr %0d actual=%h expected=%h",
                     cur_tag, bus_addr, bus_rdata, exp_read(bus_addr));
        end
        checks++;
        if (ovf_flag !== m_flag) begin
            errors++;
            $display("FAIL %s: ovf_flag actual=%b expected=%b", cur_tag, ovf_flag, m_flag);
        end
    endtask

    task automatic bus_write(input bit [2:0] a, input bit [7:0] d);
        step();
        ovf_ack = 2'b00; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input bit wr_rand, input bit gate_rand, input int ack_div,
                        input bit ctl_junk);
        step();
        bus_wr = 1'b0;
        bus_addr = 3'($urandom % 8);
        if (wr_rand && ($urandom % 50) == 0) begin
            bus_wr = 1'b1; bus_addr = 3'(2 + $urandom % 4); bus_wdata = 8'($urandom);
        end
        if (ctl_junk && ($urandom % 20) == 0) begin
            bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = {6'($urandom), 2'b11};
        end
        if (($urandom % 5) == 0) cnt_pin = 2'($urandom);
        if (gate_rand && ($urandom % 25) == 0) gate_pin = 2'($urandom);
        ovf_ack = (($urandom % ack_div) == 0) ? 2'($urandom) : 2'b00;
    endtask

    task automatic phase(input string tag, input bit [7:0] md, input bit [7:0] l0,
                         input bit [7:0] h0, input bit [7:0] l1, input bit [7:0] h1,
                         input bit [1:0] run, input int n, input bit wr_rand,
                         input bit gate_rand, input int ack_div, input bit ctl_junk);
        cur_tag = tag;
        gate_pin = 2'b11;
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, md);
        bus_write(3'd2, l0);
        bus_write(3'd3, h0);
        bus_write(3'd4, l1);
        bus_write(3'd5, h1);
        bus_write(3'd1, {6'd0, run});
        for (int i = 0; i < n; i++) idle(wr_rand, gate_rand, ack_div, ctl_junk);
    endtask

    initial begin
        void'($urandom(32'h5eed_0123));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        for (int i = 0; i < 40; i++) begin step(); bus_addr = 3'(i % 8); end
        // R2: register map, read-back and write priority while counting
        phase("R2", 8'h11, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 2'b00, 200, 1'b1, 1'b0, 1000, 1'b0);
        phase("R2", 8'h11, 8'hF0, 8'hFF, 8'h00, 8'h00, 2'b11, 2000, 1'b1, 1'b0, 40, 1'b0);
        // R3: 13-bit prescaled mode near the top of the count
        phase("R3", 8'h00, 8'h1C, 8'hFF, 8'hFE, 8'hFF, 2'b11, 3000, 1'b0, 1'b0, 60, 1'b0);
        // R4: 16-bit wrap
        phase("R4", 8'h11, 8'hF0, 8'hFF, 8'hE8, 8'hFF, 2'b11, 3000, 1'b0, 1'b0, 60, 1'b0);
        // R5: reload from the high byte
        phase("R5", 8'h22, 8'hFC, 8'hF0, 8'h00, 8'h80, 2'b11, 3000, 1'b0, 1'b0, 60, 1'b0);
        // R6: unit 0 split, high byte under unit 1's run bit
        phase("R6", 8'h13, 8'hF8, 8'hFA, 8'h00, 8'h00, 2'b11, 3000, 1'b0, 1'b0, 60, 1'b0);
        phase("R6", 8'h13, 8'h10, 8'hFD, 8'h00, 8'h00, 2'b10, 2000, 1'b0, 1'b0, 60, 1'b0);
        // R7: unit 1 in split mode holds
        phase("R7", 8'h31, 8'hF0, 8'hFF, 8'h55, 8'hAA, 2'b11, 2000, 1'b0, 1'b0, 60, 1'b0);
        // R8: pin gating and stopped units
        phase("R8", 8'h99, 8'hF0, 8'hFF, 8'hF8, 8'hFF, 2'b11, 3000, 1'b0, 1'b1, 60, 1'b0);
        phase("R8", 8'h11, 8'h20, 8'h30, 8'h40, 8'h50, 2'b00, 500, 1'b0, 1'b1, 60, 1'b0);
        // R9: external falling-edge counting
        phase("R9", 8'h55, 8'hFE, 8'hFF, 8'hF0, 8'hFF, 2'b11, 3000, 1'b0, 1'b0, 60, 1'b0);
        phase("R9", 8'h66, 8'hFA, 8'hF8, 8'hFC, 8'hF0, 2'b11, 2000, 1'b0, 1'b1, 60, 1'b0);
        // R10: frequent acknowledges, junk in control bits 7:2
        phase("R10", 8'h22, 8'hFE, 8'hFE, 8'hFD, 8'hFE, 2'b11, 3000, 1'b0, 1'b0, 3, 1'b1);
        // R1: reset while running
        cur_tag = "R1";
        step(); bus_wr = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin step(); bus_addr = 3'(i + 1); end
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin step(); bus_addr = 3'(i % 8); end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule